// File: doc/BRIEF.md
# Function Start/Stop Controller with Separate Busy Status

This block sits between a simple register port and several hardware functions. One shared control register holds a single run bit per function and nothing else, so one write can launch any set of functions together with no ordering constraint. Writing 1 to a bit always launches that function, even when the bit already reads 1. Writing 0 over a stored 1 asks a running function to wind down gracefully. Hardware never changes the stored run bits.

Each function channel gets a one-cycle start pulse and a held stop request from the block. The channel answers with done, exception and stop-acknowledge strobes. A small state machine per channel tracks whether the function is running. That running state appears only in a separate status register. The status register also holds a sticky exception flag per channel, so firmware can tell a stop caused by hardware from a stop it requested itself.

Top module: `fn_go_ctrl`

## Requirements
- R1: After reset, every run bit, Busy bit and exception flag reads 0, and no start pulse or stop request is driven. An asynchronous reset clears all of them at once.
- R2: A write to address 0 stores bits [NCH-1:0] as the run bits. In the following cycle it drives `ch_start` high for exactly one cycle on every idle channel whose written bit is 1, with all such channels starting together.
- R3: Writing 1 to a run bit that already reads 1 launches that function again, provided the channel is idle. Firmware does not have to clear the bit first.
- R4: Busy for a channel (status address 1, bit i) goes to 1 one cycle after its start pulse. It returns to 0 one cycle after the channel reports done.
- R5: Writing 0 over a stored 1 on a busy channel raises `ch_stop_req` for that channel two cycles after the write. The request stays high until the channel reports acknowledge, done or exception, and Busy falls one cycle after that.
- R6: An exception on a busy channel clears its Busy bit and sets its sticky flag (status address 1, bit NCH+i) one cycle later, and it leaves the run bit unchanged. An exception on an idle channel has no effect.
- R7: Writing 1 to status bit NCH+i clears that flag, and writing 0 leaves it alone. Writes to the Busy positions have no effect. If a new exception arrives in the same cycle as the clear, the flag stays set.
- R8: A start on a channel that is already busy is not passed on. `ch_start` stays low, Busy stays 1, and the run bit still reads back as 1.
- R9: The run register stores only NCH bits. Written bits above NCH are discarded and read back as 0.
- R10: Writes to any address other than 0 and 1 change no state and drive no start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address: 0 = run register, 1 = status register |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Combinational read data for rd_addr |
| ch_start | output | NCH | One-cycle start pulse per channel |
| ch_stop_req | output | NCH | Graceful stop request per channel, held until ended |
| ch_done | input | NCH | Channel finished normally |
| ch_exc | input | NCH | Channel halted on an exception |
| ch_stop_ack | input | NCH | Channel has honoured a stop request |

## Verification
A write to the run register shows its stored bits and its start pulse right after the write edge. Busy follows one edge later, and a stop request follows two edges after the write, because the request passes through the run-register stage and then the channel state machine. Done, exception and acknowledge strobes show in Busy and in the sticky flags one edge after they are sampled. The bench drives each vector on the falling edge and samples shortly after the next rising edge. The expected values in each vector are written for the edge at which every result becomes due, so a result that arrives one cycle early or late shows as a miscompare.

// File: rtl/fn_go_pkg.sv
package fn_go_pkg;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_RUN  = 2'd1,
    RS_STOP = 2'd2
  } run_state_e;

  localparam int unsigned ADDR_RUN  = 0;
  localparam int unsigned ADDR_STAT = 1;

endpackage

// File: rtl/fn_rst_sync.sv
module fn_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n = sync_q[STAGES-1];

endmodule

// File: rtl/fn_run_reg.sv
module fn_run_reg
  import fn_go_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  input  logic [NCH-1:0] busy,
  input  logic [NCH-1:0] exc_flag,
  output logic [NCH-1:0] start_q,
  output logic [NCH-1:0] stop_q,
  output logic [NCH-1:0] exc_clr
);

  localparam int unsigned STAT_W = 2 * NCH;

  logic           run_wr;
  logic           stat_wr;
  logic [NCH-1:0] run_q;
  logic [NCH-1:0] run_d;
  logic [NCH-1:0] start_d;
  logic [NCH-1:0] stop_d;

  always_comb begin
    run_wr  = wr_en && (wr_addr == AW'(ADDR_RUN));
    stat_wr = wr_en && (wr_addr == AW'(ADDR_STAT));
    run_d   = wr_data[NCH-1:0];
    start_d = run_wr ? wr_data[NCH-1:0] : '0;
    stop_d  = run_wr ? (run_q & ~wr_data[NCH-1:0]) : '0;
    exc_clr = stat_wr ? wr_data[STAT_W-1:NCH] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (run_wr) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      stop_q  <= '0;
    end else begin
      start_q <= start_d;
      stop_q  <= stop_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == AW'(ADDR_RUN)) begin
      rd_data[NCH-1:0] = run_q;
    end else if (rd_addr == AW'(ADDR_STAT)) begin
      rd_data[STAT_W-1:0] = {exc_flag, busy};
    end
  end

  generate
    if (DW > STAT_W) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^wr_data[DW-1:STAT_W];
    end
  endgenerate

  // R6: hardware never alters the run bits; only a firmware write does
  a_r6_run_bits_fw_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(run_wr) |-> $stable(run_q));

  // R10, R2: a start pulse exists only as the result of a run-register write
  a_r10_start_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    (start_q != '0) |-> $past(wr_en && (wr_addr == AW'(ADDR_RUN))));

endmodule

// File: rtl/fn_run_fsm.sv
module fn_run_fsm
  import fn_go_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic done,
  input  logic exc,
  input  logic ack,
  input  logic clr,
  output logic busy,
  output logic stop_req,
  output logic flag
);

  run_state_e state_q;
  run_state_e state_d;
  logic       flag_q;
  logic       flag_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_IDLE: if (start) state_d = RS_RUN;
      RS_RUN: begin
        if (exc || done)  state_d = RS_IDLE;
        else if (stop)    state_d = RS_STOP;
      end
      RS_STOP: if (exc || done || ack) state_d = RS_IDLE;
      default: state_d = RS_IDLE;
    endcase
  end

  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (exc && (state_q != RS_IDLE)) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RS_IDLE;
      flag_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      flag_q  <= flag_d;
    end
  end

  assign busy     = (state_q != RS_IDLE);
  assign stop_req = (state_q == RS_STOP);
  assign flag     = flag_q;

  // R4: an accepted start makes the channel busy on the next edge
  a_r4_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);

  // R6: an exception while running ends the run and leaves the flag set
  a_r6_exc_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && exc) |=> (!busy && flag));

  // R7: the sticky flag only rises because of an exception during a run
  a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(busy && exc));

  // R5: an acknowledged stop request ends the run on the next edge
  a_r5_ack_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && ack) |=> !busy);

  // R5: the stop request is held until the channel answers
  a_r5_stop_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !ack && !done && !exc) |=> stop_req);

endmodule

// File: rtl/fn_go_ctrl.sv
module fn_go_ctrl
  import fn_go_pkg::*;
#(
  parameter int unsigned NCH = 4,
  parameter int unsigned DW  = 32,
  parameter int unsigned AW  = 2
) (
  input  logic           clk,
  input  logic           arst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic [AW-1:0]  rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic [NCH-1:0] ch_start,
  output logic [NCH-1:0] ch_stop_req,
  input  logic [NCH-1:0] ch_done,
  input  logic [NCH-1:0] ch_exc,
  input  logic [NCH-1:0] ch_stop_ack
);

  logic           rst_n;
  logic [NCH-1:0] busy_w;
  logic [NCH-1:0] flag_w;
  logic [NCH-1:0] start_w;
  logic [NCH-1:0] stop_w;
  logic [NCH-1:0] clr_w;

  fn_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .arst_n(arst_n),
    .rst_n (rst_n)
  );

  fn_run_reg #(.NCH(NCH), .DW(DW), .AW(AW)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .busy    (busy_w),
    .exc_flag(flag_w),
    .start_q (start_w),
    .stop_q  (stop_w),
    .exc_clr (clr_w)
  );

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      fn_run_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_w[i]),
        .stop    (stop_w[i]),
        .done    (ch_done[i]),
        .exc     (ch_exc[i]),
        .ack     (ch_stop_ack[i]),
        .clr     (clr_w[i]),
        .busy    (busy_w[i]),
        .stop_req(ch_stop_req[i]),
        .flag    (flag_w[i])
      );
    end
  endgenerate

  assign ch_start = start_w & ~busy_w;

  // R2: a start pulse never lasts two cycles on one channel
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start != '0) |=> ((ch_start & $past(ch_start)) == '0));

  // R8: a busy channel never sees a start pulse on the next edge after going busy
  a_r8_start_on_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_start != '0) |=> ((busy_w & $past(ch_start)) == $past(ch_start)));

endmodule

// File: tb/sim_fn_go_ctrl.sv
`timescale 1ns/100ps
module sim_fn_go_ctrl;

  localparam int unsigned NCH = 4;
  localparam int unsigned DW  = 32;
  localparam int unsigned AW  = 2;
  localparam int NVEC = 21;

  logic           clk = 1'b0;
  logic           arst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [DW-1:0]  rd_data;
  logic [NCH-1:0] ch_start;
  logic [NCH-1:0] ch_stop_req;
  logic [NCH-1:0] ch_done = '0;
  logic [NCH-1:0] ch_exc = '0;
  logic [NCH-1:0] ch_stop_ack = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fn_go_ctrl #(.NCH(NCH), .DW(DW), .AW(AW)) u0 (
    .clk(clk), .arst_n(arst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ch_start(ch_start), .ch_stop_req(ch_stop_req), .ch_done(ch_done),
    .ch_exc(ch_exc), .ch_stop_ack(ch_stop_ack)
  );

  typedef struct packed {
    logic       we;
    logic [1:0] ad;
    logic [7:0] dt;
    logic [3:0] dn;
    logic [3:0] ex;
    logic [3:0] ak;
    logic [3:0] st;
    logic [3:0] sp;
    logic [7:0] r0;
    logic [7:0] r1;
  } vec_t;

  // we ad dt dn ex ak | expected: start stop run-read status-read
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,2'd0,8'h00,4'h0,4'h0,4'h0, 4'h0,4'h0,8'h00,8'h00}, // 0  R1 idle
    '{1'b1,2'd0,8'h05,4'h0,4'h0,4'h0, 4'h5,4'h0,8'h05,8'h00}, // 1  R2 launch ch0,ch2
    '{1'b0,2'd0,8'h00,4'h0,4'h0,4'h0, 4'h0,4'h0,8'h05,8'h05}, // 2  R4 busy rises
    '{1'b0,2'd0,8'h00,4'h1,4'h0,4'h0, 4'h0,4'h0,8'h05,8'h04}, // 3  R4 ch0 done
    '{1'b1,2'd0,8'h05,4'h0,4'h0,4'h0, 4'h1,4'h0,8'h05,8'h04}, // 4  R3 relaunch, ch2 busy
    '{1'b0,2'd0,8'h00,4'h0,4'h0,4'h0, 4'h0,4'h0,8'h05,8'h05}, // 5  R3 ch0 busy again
    '{1'b1,2'd0,8'h01,4'h0,4'h0,4'h0, 4'h0,4'h0,8'h01,8'h05}, // 6  R8 ch0 busy start dropped
    '{1'b0,2'd0,8'h00,4'h0,4'h0,4'h0, 4'h0,4'h4,8'h01,8'h05}, // 7  R5 stop request ch2
    '{1'b0,2'd0,8'h00,4'h0,4'h0,4'h0, 4'h0,4'h4,8'h01,8'h05}, // 8  R5 held
    '{1'b0,2'd0,8'h00,4'h0,4'h0,4'h4, 4'h0,4'h0,8'h01,8'h01}, // 9  R5 acknowledged
    '{1'b0,2'd0,8'h00,4'h0,4'h1,4'h0, 4'h0,4'h0,8'h01,8'h10}, // 10 R6 exception ch0
    '{1'b1,2'd1,8'h0F,4'h0,4'h0,4'h0, 4'h0,4'h0,8'h01,8'h10}, // 11 R7 busy bits write ignored
    '{1'b1,2'd1,8'h10,4'h0,4'h0,4'h0, 4'h0,4'h0,8'h01,8'h00}, // 12 R7 clear flag ch0
    '{1'b1,2'd2,8'hFF,4'h0,4'h0,4'h0, 4'h0,4'h0,8'h01,8'h00}, // 13 R10 other address
    '{1'b1,2'd0,8'hFF,4'h0,4'h0,4'h0, 4'hF,4'h0,8'h0F,8'h00}, // 14 R9 upper bits dropped
    '{1'b0,2'd0,8'h00,4'h0,4'h0,4'h0, 4'h0,4'h0,8'h0F,8'h0F}, // 15 R2 all busy
    '{1'b1,2'd0,8'h00,4'h0,4'h0,4'h0, 4'h0,4'h0,8'h00,8'h0F}, // 16 R5 stop all
    '{1'b0,2'd0,8'h00,4'h0,4'h0,4'h0, 4'h0,4'hF,8'h00,8'h0F}, // 17 R5 requests up
    '{1'b0,2'd0,8'h00,4'h8,4'h2,4'h1, 4'h0,4'h4,8'h00,8'h24}, // 18 R6 mixed endings
    '{1'b1,2'd1,8'h20,4'h0,4'h4,4'h0, 4'h0,4'h0,8'h00,8'h40}, // 19 R7 clear ch1, exc ch2
    '{1'b0,2'd0,8'h00,4'h0,4'h8,4'h0, 4'h0,4'h0,8'h00,8'h40}  // 20 R6 idle exc ignored
  };

  function automatic string req_of(int i);
    case (i)
      0:                 return "R1";
      1, 15:             return "R2";
      4, 5:              return "R3";
      2, 3:              return "R4";
      7, 8, 9, 16, 17:   return "R5";
      10, 18, 20:        return "R6";
      11, 12, 19:        return "R7";
      6:                 return "R8";
      14:                return "R9";
      default:           return "R10";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic read_both(output logic [31:0] r0, output logic [31:0] r1);
    rd_addr = AW'(0);
    #0.3;
    r0 = rd_data;
    rd_addr = AW'(1);
    #0.3;
    r1 = rd_data;
  endtask

  task automatic check_all(string req, logic [3:0] st, logic [3:0] sp,
                           logic [7:0] e0, logic [7:0] e1);
    logic [31:0] r0, r1;
    read_both(r0, r1);
    chk(req, "ch_start", 32'(ch_start), 32'(st));
    chk(req, "ch_stop_req", 32'(ch_stop_req), 32'(sp));
    chk(req, "run reg", r0, 32'(e0));
    chk(req, "status reg", r1, 32'(e1));
  endtask

  task automatic drive(logic we, logic [1:0] ad, logic [7:0] dt,
                       logic [3:0] dn, logic [3:0] ex, logic [3:0] ak);
    @(negedge clk);
    wr_en = we; wr_addr = ad; wr_data = 32'(dt);
    ch_done = dn; ch_exc = ex; ch_stop_ack = ak;
    @(posedge clk);
    #1;
    wr_en = 1'b0; ch_done = '0; ch_exc = '0; ch_stop_ack = '0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state after synchronised release
    repeat (3) @(posedge clk);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1", 4'h0, 4'h0, 8'h00, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].we, VEC[i].ad, VEC[i].dt, VEC[i].dn, VEC[i].ex, VEC[i].ak);
      check_all(req_of(i), VEC[i].st, VEC[i].sp, VEC[i].r0, VEC[i].r1);
    end

    // R7: exception and clear in the same cycle keep the flag set
    drive(1'b1, 2'd0, 8'h01, 4'h0, 4'h0, 4'h0);
    drive(1'b0, 2'd0, 8'h00, 4'h0, 4'h0, 4'h0);
    check_all("R7", 4'h0, 4'h0, 8'h01, 8'h41);
    drive(1'b1, 2'd1, 8'h10, 4'h0, 4'h1, 4'h0);
    check_all("R7", 4'h0, 4'h0, 8'h01, 8'h50);

    // R3: relaunch by rewriting 1 with no clear between
    drive(1'b1, 2'd0, 8'h01, 4'h0, 4'h0, 4'h0);
    check_all("R3", 4'h1, 4'h0, 8'h01, 8'h50);
    drive(1'b0, 2'd0, 8'h00, 4'h0, 4'h0, 4'h0);
    check_all("R3", 4'h0, 4'h0, 8'h01, 8'h51);

    // R1: asynchronous reset mid-run clears everything at once
    @(negedge clk);
    arst_n = 1'b0;
    #1;
    check_all("R1", 4'h0, 4'h0, 8'h00, 8'h00);
    @(negedge clk);
    arst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1", 4'h0, 4'h0, 8'h00, 8'h00);

    finish_run();
  end

endmodule